// File: doc/BRIEF.md
# Single-Thread Reorder Buffer with Rate-Limited Squash

This block tracks in-flight instructions of one hardware thread in a circular buffer. Each occupied slot holds a sequence number, a ready-to-commit flag and a squashed flag. New instructions enter at the tail in increasing sequence order. The oldest instruction leaves at the head once it is ready.

On a misprediction, a squash request carries a boundary sequence number. The block then walks backwards from the youngest slot toward the oldest. It handles no more than `SQ_W` slots per clock. Every visited slot younger than the boundary is marked squashed and, in the same step, ready. Nothing is deleted: squashed work drains through the normal retire path. While the walk runs, inserts, retires and further squash requests are held off. A done flag reports when the walk has finished.

Top module: `seq_reorder_buf`

## Requirements
- R1: After reset the buffer is empty. `head_ready` is 0, `head_seq` is 0, `ins_slot` is 0, `sq_busy` is 0, `sq_done` is 1, `ins_err` is 0 and every `sq_flags` bit is 0.
- R2: An insert with fewer than DEPTH occupied slots, no walk running and no squash starting is accepted. The entry goes to slot `ins_slot` with its ready and squashed flags cleared, and `ins_slot` then advances by one modulo DEPTH. `head_seq` shows the oldest sequence number, or 0 when the buffer is empty.
- R3: An insert while DEPTH slots are occupied is dropped. `ins_err` is 1 in the cycle after that request and 0 after any cycle without one. Occupancy never exceeds DEPTH.
- R4: A mark strobe sets the ready flag of slot `mark_idx`. `head_ready` is 1 exactly when the buffer is non-empty and the head slot is ready.
- R5: A retire removes the head entry only when the buffer is non-empty, the head is ready, and no walk is running or starting. Otherwise it has no effect.
- R6: A squash request while the buffer is empty is ignored: `sq_busy` stays 0 and `sq_done` stays 1.
- R7: A squash request on a non-empty, idle buffer latches the boundary. In the next cycle `sq_busy` is 1 and `sq_done` is 0. While the walk runs, inserts, retires and new squash requests have no effect, and `sq_busy` and `sq_done` are never equal.
- R8: The walk starts at the youngest entry and visits at most SQ_W slots per cycle. With N youngest entries above the boundary out of C held, `sq_busy` stays high for ceil(N/SQ_W) cycles if N equals C, and for floor(N/SQ_W)+1 cycles otherwise.
- R9: Each visited entry whose sequence number is strictly greater than the boundary gets both its squashed flag (bit i of `sq_flags` for slot i) and its ready flag set. Entries at or below the boundary keep their flags.
- R10: The walk ends at the first entry whose sequence number is at or below the boundary, or after the head entry has been marked. In that cycle `sq_busy` falls and `sq_done` rises.
- R11: Retiring a slot clears its squashed flag, so `sq_flags` bits are 1 only for occupied slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of the inserted entry |
| mark_valid | input | 1 | Mark-ready strobe |
| mark_idx | input | log2(DEPTH) | Slot to mark ready |
| retire | input | 1 | Retire the head entry |
| squash_req | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Boundary sequence number of the squash |
| ins_slot | output | log2(DEPTH) | Slot the next insert will use |
| ins_err | output | 1 | Overflowing insert was dropped last cycle |
| head_ready | output | 1 | Head entry present and ready |
| head_seq | output | SEQ_W | Sequence number of the head entry, 0 when empty |
| sq_busy | output | 1 | Squash walk in progress |
| sq_done | output | 1 | No squash walk outstanding |
| sq_flags | output | DEPTH | Squashed flag per slot |

## Verification
The bench aims at the ends of the walk.

- **Boundary above the youngest entry.** The walk must finish after one cycle and mark nothing. A design that marks before comparing would flag a live entry.
- **Boundary below every entry.** The walk must stop right after marking the head. A design that misses the head stop would wrap around into free slots.
- **Boundary equal to an existing sequence number.** This catches a `>=` where `>` belongs.
- **Busy length against the formula.** Measuring how long `sq_busy` stays high exposes a walker that is too fast or too slow.

A full buffer with one more insert must raise the error pulse for a single cycle. A retire of a non-ready head, and any insert, retire or squash issued mid-walk, must leave the observable state untouched. Squashed entries are then drained to show that their flags are cleared on retire.

// File: rtl/seq_rob_pkg.sv
package seq_rob_pkg;
   typedef enum logic {WALK_IDLE = 1'b0, WALK_RUN = 1'b1} walk_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
   parameter int DEPTH = 8,
   localparam int IW = $clog2(DEPTH),
   localparam int CW = IW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   output logic [IW-1:0] head,
   output logic [IW-1:0] tail,
   output logic [CW-1:0] occ,
   output logic          full,
   output logic          empty
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
         occ  <= '0;
      end else begin
         if (push) tail <= tail + 1'b1;
         if (pop)  head <= head + 1'b1;
         case ({push, pop})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end

   assign full  = (occ == CW'(DEPTH));
   assign empty = (occ == '0);
endmodule

// File: rtl/rob_slots.sv
module rob_slots #(
   parameter int DEPTH = 8,
   parameter int SEQ_W = 16,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [IW-1:0]               wr_idx,
   input  logic [SEQ_W-1:0]            wr_seq,
   input  logic                        rdy_en,
   input  logic [IW-1:0]               rdy_idx,
   input  logic                        pop_en,
   input  logic [IW-1:0]               pop_idx,
   input  logic [DEPTH-1:0]            sq_hit,
   output logic [DEPTH-1:0][SEQ_W-1:0] seq_all,
   output logic [DEPTH-1:0]            rdy_all,
   output logic [DEPTH-1:0]            sq_all
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [SEQ_W-1:0] r_seq;
      logic             r_rdy;
      logic             r_sq;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_seq <= '0;
            r_rdy <= 1'b0;
            r_sq  <= 1'b0;
         end else if (wr_en && wr_idx == IW'(g)) begin
            r_seq <= wr_seq;
            r_rdy <= 1'b0;
            r_sq  <= 1'b0;
         end else if (pop_en && pop_idx == IW'(g)) begin
            r_rdy <= 1'b0;
            r_sq  <= 1'b0;
         end else begin
            if (sq_hit[g]) begin
               r_sq  <= 1'b1;
               r_rdy <= 1'b1;
            end
            if (rdy_en && rdy_idx == IW'(g)) r_rdy <= 1'b1;
         end
      end

      assign seq_all[g] = r_seq;
      assign rdy_all[g] = r_rdy;
      assign sq_all[g]  = r_sq;
   end
endmodule

// File: rtl/rob_sq_walk.sv
module rob_sq_walk
   import seq_rob_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int SEQ_W = 16,
   parameter int SQ_W  = 2,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [SEQ_W-1:0]            start_bound,
   input  logic [IW-1:0]               start_cur,
   input  logic [IW-1:0]               head,
   input  logic [DEPTH-1:0][SEQ_W-1:0] seq_all,
   output logic                        busy,
   output logic                        done,
   output logic [DEPTH-1:0]            hit
);
   walk_e            state;
   logic [IW-1:0]    cur;
   logic [SEQ_W-1:0] bound;
   logic             finish;

   // Lane k looks at slot cur-k; a lane is live only while every younger lane squashed
   always_comb begin
      logic          cont;
      logic [IW-1:0] ix;
      logic          younger;
      cont   = (state == WALK_RUN);
      hit    = '0;
      finish = 1'b0;
      for (int k = 0; k < SQ_W; k++) begin
         ix      = cur - IW'(k);
         younger = (seq_all[ix] > bound);
         if (cont) begin
            if (younger) hit[ix] = 1'b1;
            if (!younger || ix == head) finish = 1'b1;
         end
         cont = cont && younger && (ix != head);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= WALK_IDLE;
         done  <= 1'b1;
         cur   <= '0;
         bound <= '0;
      end else if (state == WALK_IDLE) begin
         if (start) begin
            state <= WALK_RUN;
            done  <= 1'b0;
            cur   <= start_cur;
            bound <= start_bound;
         end
      end else if (finish) begin
         state <= WALK_IDLE;
         done  <= 1'b1;
      end else begin
         cur <= cur - IW'(SQ_W);
      end
   end

   assign busy = (state == WALK_RUN);
endmodule

// File: rtl/seq_reorder_buf.sv
module seq_reorder_buf #(
   parameter int DEPTH = 8,
   parameter int SEQ_W = 16,
   parameter int SQ_W  = 2,
   localparam int IW = $clog2(DEPTH),
   localparam int CW = IW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ins_valid,
   input  logic [SEQ_W-1:0] ins_seq,
   input  logic             mark_valid,
   input  logic [IW-1:0]    mark_idx,
   input  logic             retire,
   input  logic             squash_req,
   input  logic [SEQ_W-1:0] squash_seq,
   output logic [IW-1:0]    ins_slot,
   output logic             ins_err,
   output logic             head_ready,
   output logic [SEQ_W-1:0] head_seq,
   output logic             sq_busy,
   output logic             sq_done,
   output logic [DEPTH-1:0] sq_flags
);
   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two of at least 2");
      assert (SQ_W >= 1 && SQ_W <= DEPTH)
         else $error("SQ_W must lie in 1..DEPTH");
      assert (SEQ_W >= 1)
         else $error("SEQ_W must be positive");
   end

   logic [IW-1:0]               head, tail;
   logic [CW-1:0]               occ;
   logic                        full, empty;
   logic                        sq_start, stall, push, pop;
   logic [DEPTH-1:0][SEQ_W-1:0] seq_all;
   logic [DEPTH-1:0]            rdy_all, sq_all, sq_hit;

   assign sq_start = squash_req && !sq_busy && !empty;
   assign stall    = sq_busy || sq_start;
   assign push     = ins_valid && !full && !stall;
   assign pop      = retire && !empty && rdy_all[head] && !stall;

   rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .head  (head),
      .tail  (tail),
      .occ   (occ),
      .full  (full),
      .empty (empty)
   );

   rob_slots #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_slots (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push),
      .wr_idx  (tail),
      .wr_seq  (ins_seq),
      .rdy_en  (mark_valid),
      .rdy_idx (mark_idx),
      .pop_en  (pop),
      .pop_idx (head),
      .sq_hit  (sq_hit),
      .seq_all (seq_all),
      .rdy_all (rdy_all),
      .sq_all  (sq_all)
   );

   rob_sq_walk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQ_W(SQ_W)) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (sq_start),
      .start_bound (squash_seq),
      .start_cur   (tail - 1'b1),
      .head        (head),
      .seq_all     (seq_all),
      .busy        (sq_busy),
      .done        (sq_done),
      .hit         (sq_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ins_err <= 1'b0;
      else        ins_err <= ins_valid && full;
   end

   assign ins_slot   = tail;
   assign head_ready = !empty && rdy_all[head];
   assign head_seq   = empty ? '0 : seq_all[head];
   assign sq_flags   = sq_all;
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
   parameter int DEPTH = 8,
   parameter int SQ_W  = 2,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             squash_req,
   input logic             ins_valid,
   input logic             ins_err,
   input logic             head_ready,
   input logic             sq_busy,
   input logic             sq_done,
   input logic [DEPTH-1:0] sq_flags,
   input logic             full,
   input logic             empty,
   input logic [CW-1:0]    occ
);
   assert_err_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ins_err |-> $past(ins_valid && full));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CW'(DEPTH));

   assert_head_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !head_ready);

   assert_empty_squash_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (squash_req && empty && !sq_busy) |=> (!sq_busy && sq_done));

   assert_squash_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (squash_req && !empty && !sq_busy) |=> (sq_busy && !sq_done));

   assert_busy_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sq_busy != sq_done);

   assert_walk_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sq_busy |=> ($countones(sq_flags & ~$past(sq_flags)) <= SQ_W));

   assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sq_busy |=> (($past(sq_flags) & ~sq_flags) == '0));

   assert_walk_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sq_busy) |-> sq_done);
endmodule

bind seq_reorder_buf rob_chk #(.DEPTH(DEPTH), .SQ_W(SQ_W)) u_rob_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .squash_req (squash_req),
   .ins_valid  (ins_valid),
   .ins_err    (ins_err),
   .head_ready (head_ready),
   .sq_busy    (sq_busy),
   .sq_done    (sq_done),
   .sq_flags   (sq_flags),
   .full       (full),
   .empty      (empty),
   .occ        (occ)
);

// File: tb/test_seq_reorder_buf.sv
module test_seq_reorder_buf;
   localparam int DEPTH = 8;
   localparam int SEQ_W = 16;
   localparam int SQ_W  = 2;
   localparam int IW    = $clog2(DEPTH);

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             rst_n;
   logic             ins_valid, mark_valid, retire, squash_req;
   logic [SEQ_W-1:0] ins_seq, squash_seq;
   logic [IW-1:0]    mark_idx, ins_slot;
   logic             ins_err, head_ready, sq_busy, sq_done;
   logic [SEQ_W-1:0] head_seq;
   logic [DEPTH-1:0] sq_flags;

   seq_reorder_buf #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQ_W(SQ_W)) i_seq_reorder_buf (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_seq(ins_seq),
      .mark_valid(mark_valid), .mark_idx(mark_idx), .retire(retire),
      .squash_req(squash_req), .squash_seq(squash_seq), .ins_slot(ins_slot),
      .ins_err(ins_err), .head_ready(head_ready), .head_seq(head_seq),
      .sq_busy(sq_busy), .sq_done(sq_done), .sq_flags(sq_flags)
   );

   int checks = 0;
   int errors = 0;
   int m_seq [DEPTH];
   bit m_rdy [DEPTH];
   bit m_sq  [DEPTH];
   int m_head = 0;
   int m_cnt  = 0;
   int next_seq = 1;

   function automatic int m_tail();
      return (m_head + m_cnt) % DEPTH;
   endfunction

   function automatic logic [DEPTH-1:0] exp_flags();
      logic [DEPTH-1:0] f = '0;
      for (int i = 0; i < m_cnt; i++) f[(m_head + i) % DEPTH] = m_sq[(m_head + i) % DEPTH];
      return f;
   endfunction

   task automatic chk(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_state(string req);
      chk(req, "head_ready", head_ready, (m_cnt > 0 && m_rdy[m_head]) ? 1 : 0);
      chk(req, "head_seq", head_seq, (m_cnt > 0) ? m_seq[m_head] : 0);
      chk(req, "ins_slot", ins_slot, m_tail());
      chk(req, "sq_flags", sq_flags, exp_flags());
   endtask

   task automatic idle();
      ins_valid = 1'b0; mark_valid = 1'b0; retire = 1'b0; squash_req = 1'b0;
   endtask

   task automatic do_insert();
      bit of = (m_cnt == DEPTH);
      ins_valid = 1'b1;
      ins_seq   = SEQ_W'(next_seq);
      @(negedge clk);
      idle();
      if (!of) begin
         m_seq[m_tail()] = next_seq;
         m_rdy[m_tail()] = 1'b0;
         m_sq[m_tail()]  = 1'b0;
         m_cnt++;
         next_seq += 1 + int'($urandom % 3);
      end
      chk("R3", "ins_err", ins_err, of ? 1 : 0);
      check_state("R2");
   endtask

   task automatic do_mark(int idx);
      mark_valid = 1'b1;
      mark_idx   = IW'(idx);
      @(negedge clk);
      idle();
      m_rdy[idx] = 1'b1;
      check_state("R4");
   endtask

   task automatic do_retire();
      bit go = (m_cnt > 0 && m_rdy[m_head]);
      retire = 1'b1;
      @(negedge clk);
      idle();
      if (go) begin
         m_sq[m_head] = 1'b0;
         m_head = (m_head + 1) % DEPTH;
         m_cnt--;
      end
      check_state("R5/R11");
   endtask

   task automatic do_squash(int bound);
      int n = 0;
      int edges;
      int cyc = 0;
      while (n < m_cnt && m_seq[(m_head + m_cnt - 1 - n) % DEPTH] > bound) n++;
      edges = (n == m_cnt) ? (n + SQ_W - 1) / SQ_W : n / SQ_W + 1;
      squash_req = 1'b1;
      squash_seq = SEQ_W'(bound);
      @(negedge clk);
      idle();
      if (m_cnt == 0) begin
         chk("R6", "sq_busy", sq_busy, 0);
         chk("R6", "sq_done", sq_done, 1);
         check_state("R6");
         return;
      end
      chk("R7", "sq_busy", sq_busy, 1);
      chk("R7", "sq_done", sq_done, 0);
      // requests that must be ignored during the walk
      ins_valid  = (m_cnt < DEPTH);
      ins_seq    = SEQ_W'(next_seq);
      retire     = 1'b1;
      squash_req = 1'b1;
      squash_seq = '0;
      while (sq_busy && cyc < 1000) begin
         cyc++;
         @(negedge clk);
         idle();
      end
      chk("R8", "busy cycles", cyc, edges);
      chk("R10", "sq_done", sq_done, 1);
      for (int i = 0; i < n; i++) begin
         m_sq[(m_head + m_cnt - 1 - i) % DEPTH]  = 1'b1;
         m_rdy[(m_head + m_cnt - 1 - i) % DEPTH] = 1'b1;
      end
      check_state("R9");
   endtask

   function automatic int pick_bound();
      if (m_cnt == 0) return 0;
      return m_seq[(m_head + int'($urandom % m_cnt)) % DEPTH] - int'($urandom % 2);
   endfunction

   initial begin
      #2_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      idle();
      ins_seq = '0; mark_idx = '0; squash_seq = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "sq_busy", sq_busy, 0);
      chk("R1", "sq_done", sq_done, 1);
      chk("R1", "ins_err", ins_err, 0);
      check_state("R1");

      do_squash(5);                         // R6 empty squash
      do_retire();                          // R5 empty retire ignored
      for (int i = 0; i < DEPTH; i++) do_insert();
      do_insert();                          // R3 overflow
      @(negedge clk);
      chk("R3", "ins_err pulse", ins_err, 0);
      do_retire();                          // R5 head not ready
      do_mark((m_head + 2) % DEPTH);
      do_mark(m_head);
      do_retire();
      do_retire();                          // R5 next head not ready
      do_squash(next_seq + 10);             // R10 nothing above boundary
      do_squash(0);                         // R10 walk reaches head
      while (m_cnt > 0) do_retire();        // R9 squashed entries drain, R11
      for (int i = 0; i < DEPTH - 1; i++) do_insert();
      do_squash(m_seq[(m_head + 3) % DEPTH]); // R9 equal boundary kept

      for (int op = 0; op < 400; op++) begin
         case ($urandom % 10)
            0, 1, 2, 3: do_insert();
            4, 5: if (m_cnt > 0) do_mark((m_head + int'($urandom % m_cnt)) % DEPTH);
            6, 7: do_retire();
            8:    do_squash(pick_bound());
            default: begin @(negedge clk); check_state("R2"); end
         endcase
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule